// File: doc/BRIEF.md
# Cascadable Port Priority Arbiter

The block picks a single winning port out of thirteen port state machines of a multi-port repeater. Ports are ranked in a fixed order along a priority chain. Port 1 is the strongest and port 13 the weakest. An enable enters at the top of the chain, and an enable leaves at the bottom. When the leaving enable of one device feeds the entering enable of the next, several devices form one longer chain. Only the top device in that chain has its entering enable tied high.

Two winners are needed over the life of a packet, and each has its own qualifying rule. While the repeater sits idle, a port qualifies if it shows receive activity or a collision. The winner is the first port to become active. At the moment the repeater leaves its transmit-collision state, only a collision qualifies, and the winner is the collision port. A level input tells the block which rule applies. A one-cycle strobe tells it when to register the winner. The registered index and a valid flag then hold until the next strobe.

Top module: `port_chain_arbiter`

## Requirements
- R1: When several ports qualify, the captured winner is the one with the lowest port number. Port k sits on bit k-1 of each per-port vector, and it is reported as index k (1 to 13).
- R2: `chain_out` is high exactly when `chain_in` is high and no local port qualifies under the current rule. It is combinational, with no clock delay.
- R3: While `chain_in` is low, no port wins. A capture then gives `win_valid`=0 and `win_idx`=0, whatever the port inputs are.
- R4: With `phase_col`=0 (idle rule), a port qualifies when its activity bit or its collision bit is set.
- R5: With `phase_col`=1 (collision-exit rule), only a collision bit qualifies. An activity bit alone has no effect on the winner or on `chain_out`.
- R6: A capture is taken on the rising clock edge where `cap_stb` is high, and it shows on the outputs after that edge. Without `cap_stb`, `win_idx` and `win_valid` keep their values, even when the port inputs change.
- R7: A capture with no qualifying port gives `win_valid`=0 and `win_idx`=0.
- R8: During reset, and until the first capture after it, `win_valid`=0 and `win_idx`=0. The asynchronous reset is released synchronously, two clock edges after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chain_in | input | 1 | Enable entering the top of the chain |
| phase_col | input | 1 | Rule select: 0 idle rule, 1 collision-exit rule |
| cap_stb | input | 1 | Capture strobe for the current phase |
| port_act | input | 13 | Receive activity per port, bit k-1 = port k |
| port_col | input | 13 | Collision per port, bit k-1 = port k |
| win_idx | output | 4 | Registered winner index, 0 when none |
| win_valid | output | 1 | Registered winner valid |
| chain_out | output | 1 | Enable leaving the bottom of the chain |

## Verification
The bench targets the following cases. Ties between many ports must go to port 1; an inverted priority would pick port 13. In the collision-exit rule, a port with activity but no collision must be skipped; a design that ignores the rule would pick it. When `chain_in` is low, nothing may win; a design that drops the chain gate would report a winner. Between strobes the port inputs keep changing, and the outputs must not follow them; a design that registers without its enable would track the inputs.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int unsigned DEF_PORTS = 13;

  typedef enum logic {
    PH_IDLE  = 1'b0,
    PH_TXCOL = 1'b1
  } phase_e;
endpackage

// File: rtl/arb_rst_sync.sv
module arb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/arb_req_qual.sv
module arb_req_qual #(
  parameter int unsigned N_PORTS = arb_pkg::DEF_PORTS
) (
  input  arb_pkg::phase_e     phase,
  input  logic [N_PORTS-1:0]  act_i,
  input  logic [N_PORTS-1:0]  col_i,
  output logic [N_PORTS-1:0]  req_o
);
  import arb_pkg::*;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    always_comb begin
      if (phase == PH_TXCOL) req_o[p] = col_i[p];
      else                   req_o[p] = act_i[p] | col_i[p];
    end
  end
endmodule

// File: rtl/arb_prio_chain.sv
module arb_prio_chain #(
  parameter int unsigned N_PORTS = arb_pkg::DEF_PORTS
) (
  input  logic               en_in,
  input  logic [N_PORTS-1:0] req_i,
  output logic [N_PORTS-1:0] grant_o,
  output logic               en_out
);
  logic [N_PORTS:0] en_link;

  assign en_link[0] = en_in;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_link
    assign grant_o[p]   = en_link[p] & req_i[p];
    assign en_link[p+1] = en_link[p] & ~req_i[p];
  end

  assign en_out = en_link[N_PORTS];
endmodule

// File: rtl/arb_idx_enc.sv
module arb_idx_enc #(
  parameter int unsigned N_PORTS = arb_pkg::DEF_PORTS,
  parameter int unsigned IDX_W   = $clog2(N_PORTS + 1)
) (
  input  logic [N_PORTS-1:0] grant_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic               any_o
);
  always_comb begin
    idx_o = '0;
    for (int p = 0; p < N_PORTS; p++) begin
      if (grant_i[p]) idx_o = idx_o | IDX_W'(p + 1);
    end
    any_o = |grant_i;
  end
endmodule

// File: rtl/port_chain_arbiter.sv
module port_chain_arbiter #(
  parameter int unsigned N_PORTS = arb_pkg::DEF_PORTS,
  localparam int unsigned IDX_W  = $clog2(N_PORTS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chain_in,
  input  logic               phase_col,
  input  logic               cap_stb,
  input  logic [N_PORTS-1:0] port_act,
  input  logic [N_PORTS-1:0] port_col,
  output logic [IDX_W-1:0]   win_idx,
  output logic               win_valid,
  output logic               chain_out
);
  import arb_pkg::*;

  logic               rst_sync_n;
  logic [N_PORTS-1:0] req;
  logic [N_PORTS-1:0] grant;
  logic [IDX_W-1:0]   enc_idx;
  logic               enc_any;
  logic [IDX_W-1:0]   idx_d, idx_q;
  logic               vld_d, vld_q;
  phase_e             phase;

  assign phase = phase_col ? PH_TXCOL : PH_IDLE;

  arb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  arb_req_qual #(.N_PORTS(N_PORTS)) u_qual (
    .phase (phase),
    .act_i (port_act),
    .col_i (port_col),
    .req_o (req)
  );

  arb_prio_chain #(.N_PORTS(N_PORTS)) u_chain (
    .en_in   (chain_in),
    .req_i   (req),
    .grant_o (grant),
    .en_out  (chain_out)
  );

  arb_idx_enc #(.N_PORTS(N_PORTS), .IDX_W(IDX_W)) u_enc (
    .grant_i (grant),
    .idx_o   (enc_idx),
    .any_o   (enc_any)
  );

  // next-state
  always_comb begin
    idx_d = idx_q;
    vld_d = vld_q;
    if (cap_stb) begin
      idx_d = enc_idx;
      vld_d = enc_any;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      idx_q <= '0;
      vld_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      vld_q <= vld_d;
    end
  end

  assign win_idx   = idx_q;
  assign win_valid = vld_q;

  // R1: at most one port granted
  a_r1_single_grant: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(grant));
  // R2: an outgoing enable excludes any local grant
  a_r2_out_excl: assert property (@(posedge clk) disable iff (!rst_sync_n)
    chain_out |-> (grant == '0));
  // R3: no incoming enable, no grant
  a_r3_gate: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !chain_in |-> (grant == '0) && !chain_out);
  // R6: hold between strobes
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cap_stb |=> $stable(win_idx) && $stable(win_valid));
  // R7: invalid reads as zero
  a_r7_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !win_valid |-> (win_idx == '0));
  // R1: valid index lies in port range
  a_r1_range: assert property (@(posedge clk) disable iff (!rst_sync_n)
    win_valid |-> (win_idx >= IDX_W'(1)) && (win_idx <= IDX_W'(N_PORTS)));
endmodule

// File: tb/port_chain_arbiter_test.sv
module port_chain_arbiter_test;
  localparam int NP = 13;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          chain_in, phase_col, cap_stb;
  logic [NP-1:0] port_act, port_col;
  logic [3:0]    win_idx;
  logic          win_valid, chain_out;

  int checks = 0;
  int failures = 0;
  int m_idx = 0;
  int m_vld = 0;
  bit done = 0;

  always #5 clk = ~clk;

  port_chain_arbiter uut (
    .clk(clk), .rst_n(rst_n), .chain_in(chain_in), .phase_col(phase_col),
    .cap_stb(cap_stb), .port_act(port_act), .port_col(port_col),
    .win_idx(win_idx), .win_valid(win_valid), .chain_out(chain_out)
  );

  function automatic int ref_winner(logic cin, logic ph, logic [NP-1:0] a, logic [NP-1:0] c);
    if (!cin) return 0;
    for (int k = 1; k <= NP; k++) begin
      if (ph ? c[k-1] : (a[k-1] | c[k-1])) return k;
    end
    return 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic cin, logic ph, logic stb,
                      logic [NP-1:0] a, logic [NP-1:0] c);
    int w;
    chain_in = cin; phase_col = ph; cap_stb = stb; port_act = a; port_col = c;
    #1;
    w = ref_winner(cin, ph, a, c);
    chk({tag, " chain_out"}, int'(chain_out), (cin && w == 0) ? 1 : 0);
    @(posedge clk);
    if (stb) begin
      m_idx = w;
      m_vld = (w != 0) ? 1 : 0;
    end
    @(negedge clk);
    chk({tag, " win_idx"}, int'(win_idx), m_idx);
    chk({tag, " win_valid"}, int'(win_valid), m_vld);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; chain_in = 1'b1; phase_col = 1'b0; cap_stb = 1'b0;
    port_act = '0; port_col = '0;
    repeat (3) @(negedge clk);
    chk("R8 reset idx", int'(win_idx), 0);
    chk("R8 reset valid", int'(win_valid), 0);
    rst_n = 1'b1;
    // R8: synchronised release, inputs active but no strobe
    step("R8", 1, 0, 0, 13'h1FFF, '0);
    step("R8", 1, 0, 0, 13'h1FFF, '0);
    step("R8", 1, 0, 0, 13'h1FFF, '0);
    // R1: all ports active, port 1 wins
    step("R1", 1, 0, 1, 13'h1FFF, 13'h0000);
    // R1: ports 5 and 9 active
    step("R1", 1, 0, 1, 13'h0110, 13'h0000);
    // R4: only a collision bit at port 13 qualifies in idle rule
    step("R4", 1, 0, 1, 13'h0000, 13'h1000);
    // R6: inputs change without strobe, outputs hold
    step("R6", 1, 0, 0, 13'h0001, 13'h0000);
    step("R6", 1, 0, 0, 13'h0000, 13'h0000);
    // R5: activity at port 2 ignored, collision at port 7 wins
    step("R5", 1, 1, 1, 13'h0002, 13'h0040);
    // R5: activity only, nothing qualifies, chain_out high
    step("R5", 1, 1, 1, 13'h1FFF, 13'h0000);
    // R3: chain_in low blocks a winner
    step("R3", 0, 0, 1, 13'h1FFF, 13'h1FFF);
    step("R1", 1, 0, 1, 13'h0000, 13'h0004);
    step("R3", 0, 1, 1, 13'h0000, 13'h0008);
    // R7: nothing qualifies in idle rule
    step("R1", 1, 0, 1, 13'h1000, 13'h0000);
    step("R7", 1, 0, 1, 13'h0000, 13'h0000);
    // R2: chain_out tracking with no strobe
    step("R2", 1, 0, 0, 13'h0000, 13'h0000);
    step("R2", 0, 0, 0, 13'h0000, 13'h0000);
    step("R2", 1, 1, 0, 13'h0800, 13'h0000);
    // mixed patterns
    for (int i = 0; i < 400; i++) begin
      logic ph;
      ph = 1'($urandom);
      step(ph ? "R5" : "R4", 1'($urandom_range(0, 7) != 0), ph,
           1'($urandom), 13'($urandom) & 13'($urandom), 13'($urandom) & 13'($urandom));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule